// File: doc/BRIEF.md
# Synchronous Local-Bus Slave Cycle Controller

This block is the slave end of a 32-bit synchronous local bus. It runs on the bus clock. When the host starts a read or write cycle, the block latches the request. It then turns the active-low byte enables into a lane mask and carries out the transfer against a small bank of 32-bit registers. After that it pulls its ready strobe low for one clock. The cycle ends only when the host answers with its active-low ready-return. On a read, the data stays driven until that answer is seen.

A mode input selects how ready-return is used, and it is latched when each cycle is accepted. In handshake mode, ready-return closes the cycle. It may come in the same clock as the strobe or any later clock. In burst mode, ready-return is sampled on the falling clock edge. Each falling edge on which it is held low adds one wait state. The cycle closes at the first falling edge that finds it high. In either mode, a wait that goes on for TIMEOUT clocks abandons the cycle.

Top module: `lbs_slave`

## Requirements
- R1: After the clock edge that accepts a cycle and one transfer clock, `srdy_n` is low for exactly one clock, once per accepted cycle.
- R2: In handshake mode (`mode_burst`=0), `rdy_ret_n` low at the end of the strobe clock closes the cycle at once. Otherwise the block waits, and `rdy_ret_n` low at the end of any later clock closes it.
- R3: For a read, `rdata_oe` is high and `rdata` holds steady from the strobe clock through the clock whose closing edge ends the cycle. `rdata_oe` is low for writes and when idle, and `rdata` is zero whenever `rdata_oe` is low.
- R4: In burst mode (`mode_burst`=1), `rdy_ret_n` is captured on each falling edge. If the capture during the strobe clock is low, one wait state follows for each consecutive low capture. The cycle closes after the first wait clock whose capture is high. If the capture is high during the strobe clock, the cycle closes with no wait state.
- R5: The enables `be_n[3:0]` (lane k = data bits 8k+7..8k, active low) decode as follows: 4'h0 selects all lanes, 4'hC lanes 0-1, 4'h3 lanes 2-3, 4'hE lane 0, 4'hD lane 1, 4'hB lane 2 and 4'h7 lane 3. Every other value is invalid.
- R6: A write changes only the selected lanes of the register at `cyc_addr`.
- R7: A read returns the register at `cyc_addr` with the unselected lanes forced to zero.
- R8: A cycle with an invalid enable pattern still strobes ready once. It writes nothing, and a read returns zero.
- R9: If no return closes the cycle after TIMEOUT wait clocks (default 16), the block goes idle with no further strobe and accepts the next cycle normally.
- R10: `cyc_valid` is sampled only when idle. A request raised while a cycle is in progress is dropped and has no effect on any register.
- R11: While `rst_n` is low at a clock edge, the outputs go to `srdy_n`=1, `rdata_oe`=0 and `rdata`=0, all registers clear, and the block is idle.
- R12: The mode is taken from `mode_burst` on the accepting edge. Changing `mode_burst` mid-cycle has no effect on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_burst | input | 1 | 0: handshake mode, 1: burst wait-state mode |
| cyc_valid | input | 1 | Host requests a cycle (sampled when idle) |
| cyc_write | input | 1 | 1 for write, 0 for read |
| cyc_addr | input | ADDR_W | Register index |
| be_n | input | DATA_W/8 | Active-low byte enables |
| wdata | input | DATA_W | Write data |
| rdy_ret_n | input | 1 | Active-low ready-return from host |
| srdy_n | output | 1 | Active-low ready strobe |
| rdata_oe | output | 1 | Read data is being driven |
| rdata | output | DATA_W | Read data, zero when not driven |

## Verification
A behavioural model runs alongside the block and predicts the strobe, the output enable and the read data on every clock. The handshake is tried with the return arriving in the same clock, one clock late, several clocks late, and never. These cases separate a controller that only samples during the strobe from one that truly waits, and they expose the timeout. Burst mode is tried with return held for zero, one, several and more than TIMEOUT falling edges, and the mode input is flipped after every accept to show it is latched. All sixteen enable patterns are written as all-ones over a cleared register, which sets the decode table apart from near misses. A request is also raised mid-cycle to show it is dropped.

// File: rtl/lbs_pkg.sv
// Package: shared types for the local-bus slave.
// Assumes: nothing beyond IEEE 1800-2017.
package lbs_pkg;

    // Handshake controller states.
    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_XFER       = 3'd1,
        ST_READY      = 3'd2,
        ST_WAIT_RET   = 3'd3,
        ST_WAIT_STATE = 3'd4
    } lbs_state_e;

endpackage

// File: rtl/lbs_be_decode.sv
// Module: byte-enable decoder.
// Turns active-low enables into an active-high lane mask. Legal patterns are
// all lanes, either aligned half, or one single lane. Anything else is flagged
// invalid and yields an empty mask.
// Assumes: LANES is even and at least 2.
module lbs_be_decode #(
    parameter int LANES = 4
) (
    input  logic [LANES-1:0] be_n,
    output logic [LANES-1:0] lane_mask,
    output logic             valid
);

    localparam int              HALF    = LANES / 2;
    localparam logic [LANES-1:0] ALL_ON = {LANES{1'b1}};
    localparam logic [LANES-1:0] LO_HALF = ALL_ON >> HALF;
    localparam logic [LANES-1:0] HI_HALF = LO_HALF << HALF;

    logic [LANES-1:0] en;
    logic [LANES-1:0] single_hit;

    assign en = ~be_n;

    // One comparator per lane that flags a lone single-lane enable.
    for (genvar g = 0; g < LANES; g++) begin : g_single
        localparam logic [LANES-1:0] ONE_LANE = LANES'(1) << g;
        assign single_hit[g] = (en == ONE_LANE);
    end

    // Classify the pattern and gate the mask with validity.
    always_comb begin
        valid     = (|single_hit) || (en == ALL_ON) || (en == LO_HALF) || (en == HI_HALF);
        lane_mask = valid ? en : '0;
    end

endmodule

// File: rtl/lbs_regbank.sv
// Module: register bank behind the slave.
// NUM_REGS words of DATA_W bits. Lane-masked writes, and a read port that
// zeroes the lanes that are not selected.
// Assumes: DATA_W is a multiple of 8.
module lbs_regbank #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W/8-1:0] lane_mask,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rd_data
);

    localparam int LANES    = DATA_W / 8;
    localparam int NUM_REGS = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [NUM_REGS];
    logic [DATA_W-1:0] byte_mask;

    // Widen each lane bit to a full byte of mask.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign byte_mask[l*8 +: 8] = {8{lane_mask[l]}};
    end

    // Clear on reset and write only the selected lanes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_REGS; r++) begin
                mem[r] <= '0;
            end
        end else if (wr_en) begin
            for (int l = 0; l < LANES; l++) begin
                if (lane_mask[l]) begin
                    mem[addr][l*8 +: 8] <= wdata[l*8 +: 8];
                end
            end
        end
    end

    // Masked read of the addressed word.
    assign rd_data = mem[addr] & byte_mask;

endmodule

// File: rtl/lbs_hs_fsm.sv
// Module: cycle handshake controller.
// Sequence: IDLE -> XFER -> READY (strobe) -> optional wait -> IDLE.
// In handshake mode it waits for a ready-return sampled on the rising edge.
// In burst mode it inserts wait states while a falling-edge capture of
// ready-return stays low. Any wait ends after TIMEOUT clocks.
// Assumes: TIMEOUT >= 1, and inputs are synchronous to clk.
module lbs_hs_fsm
    import lbs_pkg::*;
#(
    parameter int TIMEOUT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_valid,
    input  logic mode_in,
    input  logic rdy_ret_n,
    output logic accept,
    output logic xfer,
    output logic hold,
    output logic srdy_n
);

    localparam int               CNT_W = $clog2(TIMEOUT + 1);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(TIMEOUT - 1);

    lbs_state_e       state, state_nx;
    logic [CNT_W-1:0] wait_cnt;
    logic             mode_q;
    logic             ret_fall_q;
    logic             limit;

    // Capture ready-return on the falling edge for burst mode.
    always_ff @(negedge clk) begin
        if (!rst_n) ret_fall_q <= 1'b1;
        else        ret_fall_q <= rdy_ret_n;
    end

    assign limit = (wait_cnt == LAST);

    // Next-state decision for the handshake sequence.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:       if (cyc_valid) state_nx = ST_XFER;
            ST_XFER:       state_nx = ST_READY;
            ST_READY: begin
                if (mode_q) state_nx = ret_fall_q ? ST_IDLE : ST_WAIT_STATE;
                else        state_nx = rdy_ret_n  ? ST_WAIT_RET : ST_IDLE;
            end
            ST_WAIT_RET:   if (!rdy_ret_n || limit) state_nx = ST_IDLE;
            ST_WAIT_STATE: if (ret_fall_q || limit) state_nx = ST_IDLE;
            default:       state_nx = ST_IDLE;
        endcase
    end

    // State register, wait counter and per-cycle mode latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            wait_cnt <= '0;
            mode_q   <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_WAIT_RET || state == ST_WAIT_STATE) wait_cnt <= wait_cnt + 1'b1;
            else                                                 wait_cnt <= '0;
            if (state == ST_IDLE && cyc_valid) mode_q <= mode_in;
        end
    end

    assign accept = (state == ST_IDLE) && cyc_valid;
    assign xfer   = (state == ST_XFER);
    assign hold   = (state == ST_READY) || (state == ST_WAIT_RET) || (state == ST_WAIT_STATE);
    assign srdy_n = (state != ST_READY);

    AST_SRDY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !srdy_n |=> srdy_n); // R1
    AST_SRDY_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(srdy_n) |-> $past(xfer)); // R1
    AST_RETURN_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_RET && !rdy_ret_n) |=> (state == ST_IDLE)); // R2
    AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_STATE && !ret_fall_q && !limit) |=> (state == ST_WAIT_STATE)); // R4
    AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> (wait_cnt < CNT_W'(TIMEOUT))); // R9
    AST_MODE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> $stable(mode_q)); // R12

endmodule

// File: rtl/lbs_slave.sv
// Module: synchronous local-bus slave (top).
// Latches a host request, decodes its enables, performs the transfer on the
// register bank, and runs the ready / ready-return handshake. Read data is
// driven from the strobe clock until the cycle closes.
// Assumes: DATA_W = 32 for the four-lane enable table. All inputs are
// synchronous to clk, and reset is synchronous and active low.
module lbs_slave
    import lbs_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 3,
    parameter int TIMEOUT = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_burst,
    input  logic                cyc_valid,
    input  logic                cyc_write,
    input  logic [ADDR_W-1:0]   cyc_addr,
    input  logic [DATA_W/8-1:0] be_n,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                rdy_ret_n,
    output logic                srdy_n,
    output logic                rdata_oe,
    output logic [DATA_W-1:0]   rdata
);

    localparam int LANES = DATA_W / 8;

    logic              accept, xfer, hold;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LANES-1:0]  be_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  lane_mask;
    logic              dec_valid;
    logic [DATA_W-1:0] bank_rd;
    logic [DATA_W-1:0] rdata_q;

    lbs_hs_fsm #(.TIMEOUT(TIMEOUT)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_valid (cyc_valid),
        .mode_in   (mode_burst),
        .rdy_ret_n (rdy_ret_n),
        .accept    (accept),
        .xfer      (xfer),
        .hold      (hold),
        .srdy_n    (srdy_n)
    );

    lbs_be_decode #(.LANES(LANES)) u_dec (
        .be_n      (be_q),
        .lane_mask (lane_mask),
        .valid     (dec_valid)
    );

    lbs_regbank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (xfer && wr_q && dec_valid),
        .addr      (addr_q),
        .lane_mask (lane_mask),
        .wdata     (wdata_q),
        .rd_data   (bank_rd)
    );

    // Latch the request attributes when a cycle is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            addr_q  <= '0;
            be_q    <= '1;
            wdata_q <= '0;
        end else if (accept) begin
            wr_q    <= cyc_write;
            addr_q  <= cyc_addr;
            be_q    <= be_n;
            wdata_q <= wdata;
        end
    end

    // Capture read data during the transfer clock.
    always_ff @(posedge clk) begin
        if (!rst_n)          rdata_q <= '0;
        else if (xfer && !wr_q) rdata_q <= dec_valid ? bank_rd : '0;
    end

    assign rdata_oe = hold && !wr_q;
    assign rdata    = rdata_oe ? rdata_q : '0;

    AST_OE_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdata_oe) |-> !srdy_n); // R3
    AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_oe && $past(rdata_oe)) |-> $stable(rdata)); // R3
    AST_INVALID_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !dec_valid) |-> (lane_mask == '0)); // R8
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> ($stable(addr_q) && $stable(wr_q))); // R10

endmodule

// File: tb/tb_lbs_slave.sv
module tb_lbs_slave;

    localparam int TO = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_burst = 1'b0;
    logic        cyc_valid = 1'b0;
    logic        cyc_write = 1'b0;
    logic [2:0]  cyc_addr = '0;
    logic [3:0]  be_n = 4'hF;
    logic [31:0] wdata = '0;
    logic        rdy_ret_n = 1'b1;
    logic        srdy_n;
    logic        rdata_oe;
    logic [31:0] rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit cmp_on = 1'b0;

    always #4 clk = ~clk;

    lbs_slave dut (
        .clk(clk), .rst_n(rst_n), .mode_burst(mode_burst), .cyc_valid(cyc_valid),
        .cyc_write(cyc_write), .cyc_addr(cyc_addr), .be_n(be_n), .wdata(wdata),
        .rdy_ret_n(rdy_ret_n), .srdy_n(srdy_n), .rdata_oe(rdata_oe), .rdata(rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Lane selection per the enable table of R5.
    function automatic logic [31:0] exp_bytes(input logic [3:0] b);
        logic [3:0] m;
        case (b)
            4'h0: m = 4'b1111;
            4'hC: m = 4'b0011;
            4'h3: m = 4'b1100;
            4'hE: m = 4'b0001;
            4'hD: m = 4'b0010;
            4'hB: m = 4'b0100;
            4'h7: m = 4'b1000;
            default: m = 4'b0000;
        endcase
        return {{8{m[3]}}, {8{m[2]}}, {8{m[1]}}, {8{m[0]}}};
    endfunction

    // Behavioural reference model: phase 0 idle, 1 transfer, 2 strobe, 3 waiting.
    logic [31:0] m_mem [8];
    int          m_ph, m_wait;
    bit          m_mode, m_wr, m_retf;
    int          m_addr;
    logic [3:0]  m_be;
    logic [31:0] m_wd, m_rdv;

    always @(negedge clk) m_retf = rst_n ? rdy_ret_n : 1'b1;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_wait = 0; m_mode = 0; m_wr = 0; m_rdv = '0;
            for (int i = 0; i < 8; i++) m_mem[i] = '0;
        end else begin
            case (m_ph)
                0: if (cyc_valid) begin
                    m_wr = cyc_write; m_addr = int'(cyc_addr); m_be = be_n;
                    m_wd = wdata; m_mode = mode_burst; m_ph = 1;
                end
                1: begin
                    if (m_wr) m_mem[m_addr] = (m_mem[m_addr] & ~exp_bytes(m_be)) | (m_wd & exp_bytes(m_be));
                    else      m_rdv = m_mem[m_addr] & exp_bytes(m_be);
                    m_ph = 2;
                end
                2: begin
                    m_wait = 0;
                    if (m_mode) m_ph = m_retf ? 0 : 3;
                    else        m_ph = rdy_ret_n ? 3 : 0;
                end
                default: begin
                    if ((m_mode && m_retf) || (!m_mode && !rdy_ret_n)) m_ph = 0;
                    else begin
                        m_wait++;
                        if (m_wait == TO) m_ph = 0;
                    end
                end
            endcase
        end
    end

    // Per-clock comparison against the model, away from the edge.
    always @(posedge clk) begin
        #6;
        if (cmp_on) begin
            chk("R1 srdy_n per clock", {31'd0, srdy_n}, {31'd0, m_ph != 2});
            chk("R3 rdata_oe per clock", {31'd0, rdata_oe}, {31'd0, (m_ph >= 2) && !m_wr});
            chk("R3 rdata per clock", rdata, ((m_ph >= 2) && !m_wr) ? m_rdv : 32'd0);
        end
    end

    // One host cycle. dly: handshake return delay (-1 never). hld: burst hold length.
    task automatic bus_cycle(input bit wr, input logic [2:0] a, input logic [3:0] b,
                             input logic [31:0] wd, input bit md, input int dly,
                             input int hld, input bit poke,
                             output int oe_cnt, output int sr_cnt, output logic [31:0] rv);
        bit got = 0;
        oe_cnt = 0; sr_cnt = 0; rv = '0;
        @(posedge clk); #2;
        cyc_valid = 1; cyc_write = wr; cyc_addr = a; be_n = b; wdata = wd; mode_burst = md;
        for (int c = 1; c <= 22; c++) begin
            @(posedge clk); #2;
            if (c == 1) begin cyc_valid = 0; mode_burst = ~md; end
            if (poke && c == 3) begin
                cyc_valid = 1; cyc_write = 1; cyc_addr = 3'd2; be_n = 4'h0; wdata = 32'hDEADBEEF;
            end
            if (poke && c == 4) cyc_valid = 0;
            if (md) rdy_ret_n = !(c >= 2 && c < 2 + hld);
            else    rdy_ret_n = !(c == 2 + dly);
            #4;
            if (rdata_oe) begin
                oe_cnt++;
                if (!got) begin rv = rdata; got = 1; end
            end
            if (!srdy_n) sr_cnt++;
        end
        rdy_ret_n = 1;
    endtask

    initial begin
        #(200000 * 8);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int oe, sr;
        logic [31:0] rv;
        repeat (3) @(posedge clk);
        #6;
        chk("R11 reset srdy_n", {31'd0, srdy_n}, 32'd1);
        chk("R11 reset rdata_oe", {31'd0, rdata_oe}, 32'd0);
        chk("R11 reset rdata", rdata, 32'd0);
        cmp_on = 1;
        #2 rst_n = 1;

        bus_cycle(0, 3'd1, 4'h0, 0, 0, 0, 0, 0, oe, sr, rv);
        chk("R11 register clear after reset", rv, 32'd0);

        bus_cycle(1, 3'd1, 4'h0, 32'hA1B2C3D4, 0, 0, 0, 0, oe, sr, rv);
        chk("R1 one strobe per write", sr, 1);
        chk("R3 no oe on write", oe, 0);
        bus_cycle(0, 3'd1, 4'h0, 0, 0, 0, 0, 0, oe, sr, rv);
        chk("R6 dword readback", rv, 32'hA1B2C3D4);
        chk("R2 same-clock return oe length", oe, 1);
        bus_cycle(0, 3'd1, 4'h0, 0, 0, 1, 0, 0, oe, sr, rv);
        chk("R2 one-late return oe length", oe, 2);
        chk("R1 one strobe on late return", sr, 1);
        bus_cycle(0, 3'd1, 4'h0, 0, 0, 5, 0, 0, oe, sr, rv);
        chk("R3 data held until return", oe, 6);

        bus_cycle(1, 3'd1, 4'hD, 32'h11223344, 0, 0, 0, 0, oe, sr, rv);
        bus_cycle(0, 3'd1, 4'h0, 0, 0, 0, 0, 0, oe, sr, rv);
        chk("R6 byte1 write", rv, 32'hA1B233D4);
        bus_cycle(1, 3'd1, 4'hC, 32'h55667788, 0, 0, 0, 0, oe, sr, rv);
        bus_cycle(1, 3'd1, 4'h3, 32'h99AA0000, 0, 0, 0, 0, oe, sr, rv);
        bus_cycle(0, 3'd1, 4'h0, 0, 0, 0, 0, 0, oe, sr, rv);
        chk("R6 word writes", rv, 32'h99AA7788);
        bus_cycle(0, 3'd1, 4'hB, 0, 0, 0, 0, 0, oe, sr, rv);
        chk("R7 byte2 masked read", rv, 32'h00AA0000);
        bus_cycle(0, 3'd1, 4'hC, 0, 0, 0, 0, 0, oe, sr, rv);
        chk("R7 low word masked read", rv, 32'h00007788);

        bus_cycle(1, 3'd1, 4'h5, 32'hFFFFFFFF, 0, 0, 0, 0, oe, sr, rv);
        chk("R8 invalid write still strobes", sr, 1);
        bus_cycle(0, 3'd1, 4'h6, 0, 0, 0, 0, 0, oe, sr, rv);
        chk("R8 invalid read is zero", rv, 32'd0);
        bus_cycle(0, 3'd1, 4'h0, 0, 0, 0, 0, 0, oe, sr, rv);
        chk("R8 invalid write left register", rv, 32'h99AA7788);

        for (int p = 0; p < 16; p++) begin
            bus_cycle(1, 3'd3, 4'h0, 32'h0, 0, 0, 0, 0, oe, sr, rv);
            bus_cycle(1, 3'd3, 4'(p), 32'hFFFFFFFF, 0, 0, 0, 0, oe, sr, rv);
            chk("R5 strobe per pattern", sr, 1);
            bus_cycle(0, 3'd3, 4'h0, 0, 0, 0, 0, 0, oe, sr, rv);
            chk("R5 decode of pattern", rv, exp_bytes(4'(p)));
        end

        bus_cycle(0, 3'd1, 4'h0, 0, 0, -1, 0, 0, oe, sr, rv);
        chk("R9 handshake timeout length", oe, 1 + TO);
        chk("R9 single strobe on timeout", sr, 1);
        bus_cycle(0, 3'd1, 4'h0, 0, 0, 0, 0, 0, oe, sr, rv);
        chk("R9 normal cycle after timeout", rv, 32'h99AA7788);

        bus_cycle(0, 3'd1, 4'h0, 0, 1, 0, 0, 0, oe, sr, rv);
        chk("R4 burst no wait", oe, 1);
        bus_cycle(0, 3'd1, 4'h0, 0, 1, 0, 1, 0, oe, sr, rv);
        chk("R4 burst one wait", oe, 2);
        bus_cycle(0, 3'd1, 4'h0, 0, 1, 0, 3, 0, oe, sr, rv);
        chk("R4 R12 burst three waits", oe, 4);
        chk("R4 burst data", rv, 32'h99AA7788);
        bus_cycle(0, 3'd1, 4'h0, 0, 1, 0, 20, 0, oe, sr, rv);
        chk("R9 burst timeout", oe, 1 + TO);
        bus_cycle(0, 3'd1, 4'h0, 0, 0, 2, 0, 0, oe, sr, rv);
        chk("R12 handshake after burst flip", oe, 3);

        bus_cycle(1, 3'd1, 4'h0, 32'h01020304, 0, 3, 0, 1, oe, sr, rv);
        chk("R10 one strobe despite mid request", sr, 1);
        bus_cycle(0, 3'd2, 4'h0, 0, 0, 0, 0, 0, oe, sr, rv);
        chk("R10 mid-cycle request dropped", rv, 32'd0);

        repeat (2) @(posedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule